// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block sits beside a serial audio receiver and checks that the master clock and the frame clock (the left/right clock, which toggles once per sample period) agree with the selected rate mode. It counts master-clock cycles from one rising edge of the frame clock to the next. The count is then matched against the four oversampling ratios that are legal in the current mode. The result comes out as a 2-bit slot index into that mode's ratio set, plus a valid flag, an error flag and a lock flag. Downstream logic can hold off the data path until lock is reported.

Three rate modes are supported. Each step up in mode halves every legal ratio: the low-rate mode serves roughly 16 to 55 kHz sample rates, the mid-rate mode roughly 45 to 105 kHz, and the high-rate mode roughly 95 to 200 kHz. The frame clock arrives asynchronously and is synchronized inside the block. The block does not measure absolute frequency and does not generate any clock.

Top module: `mclk_ratio_detector`

## Requirements
- R1: After reset, and until one complete frame-clock period (rising edge to rising edge) has been measured, valid_o, err_o, lock_o and ratio_idx_o are all 0.
- R2: The frame clock passes through a two-flop synchronizer. The measured period is the number of master-clock cycles between consecutive synchronized rising edges. The outputs reflect each new measurement within 5 master-clock cycles of the rising edge that ends the period.
- R3: With mode_i = 0, the legal ratios are 256, 384, 512 and 768, reported as ratio_idx_o = 0, 1, 2 and 3 with valid_o = 1 and err_o = 0.
- R4: With mode_i = 1, the legal ratios are 128, 192, 256 and 384, reported as indices 0 to 3.
- R5: With mode_i = 2, the legal ratios are 64, 96, 128 and 192, reported as indices 0 to 3.
- R6: A period within 2 cycles of a legal ratio (inclusive) is classified as that ratio. A period 3 or more cycles away from every legal ratio is an error.
- R7: A period that matches no legal ratio gives err_o = 1, valid_o = 0 and ratio_idx_o = 0. With mode_i = 3, every period is an error. valid_o and err_o are never both 1.
- R8: lock_o rises once three consecutive measurements give the same legal classification. lock_o is never 1 while valid_o is 0.
- R9: lock_o falls on the first measurement whose classification (index or error) differs from the previous one.
- R10: If the frame clock stops, then 1023 cycles after its last rising edge the counter saturates at 1023. This is reported once as an error measurement, which clears lock. The next rising edge also measures 1023.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_clk_i | input | 1 | Frame (left/right) clock, asynchronous to clk_i |
| mode_i | input | 2 | Rate mode: 0 low, 1 mid, 2 high, 3 unsupported |
| ratio_idx_o | output | 2 | Slot of the matched ratio within the mode's set |
| valid_o | output | 1 | Latest measurement matched a legal ratio |
| err_o | output | 1 | Latest measurement matched no legal ratio |
| lock_o | output | 1 | Same legal ratio seen on three or more consecutive periods |

## Verification
The hardest state to reach from the ports is the saturated counter. It needs the frame clock to stay still for more than a thousand master-clock cycles after the block has armed, and the path through it includes the edge that ends the stall. The bench reaches it with a directed stall after a locked run. It then restarts the frame clock and steps through the recovery measurements. Lock loss is provoked by random mixes of mode changes, periods at the ±2 tolerance edge, and periods 3 cycles outside it.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

   localparam int unsigned RATIO_SLOTS = 4;
   localparam logic [1:0]  MODE_UNSUPPORTED = 2'd3;

   typedef struct packed {
      logic       bad;
      logic [1:0] slot;
   } ratio_class_t;

   // Low-rate ratio for a slot: 256, 384, 512, 768; each mode step halves it
   function automatic int unsigned base_ratio(int unsigned slot);
      return (((slot % 2) == 1) ? 3 : 2) << (7 + slot / 2);
   endfunction

endpackage

// File: rtl/mrd_sync.sv
module mrd_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic rise_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mrd_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_i};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign rise_o = chain_q[STAGES-1] & ~last_q;

   a_r2_rise_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o |=> !rise_o);

endmodule

// File: rtl/mrd_period_counter.sv
module mrd_period_counter #(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             rise_i,
   output logic             meas_stb_o,
   output logic [CNT_W-1:0] meas_cnt_o,
   output logic             armed_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q, meas_q;
   logic             armed_q, fired_q, stb_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         meas_q  <= '0;
         armed_q <= 1'b0;
         fired_q <= 1'b0;
         stb_q   <= 1'b0;
      end else begin
         stb_q <= 1'b0;
         if (rise_i) begin
            cnt_q   <= CNT_W'(1);
            armed_q <= 1'b1;
            fired_q <= 1'b0;
            if (armed_q) begin
               stb_q  <= 1'b1;
               meas_q <= cnt_q;
            end
         end else begin
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
            if (armed_q && !fired_q && cnt_q == CNT_MAX) begin
               stb_q   <= 1'b1;
               meas_q  <= CNT_MAX;
               fired_q <= 1'b1;
            end
         end
      end
   end

   assign meas_stb_o = stb_q;
   assign meas_cnt_o = meas_q;
   assign armed_o    = armed_q;

   a_r2_meas_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      meas_stb_o |-> meas_cnt_o != '0);

   a_r10_single_timeout: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (meas_stb_o && meas_cnt_o == CNT_MAX) |=> !meas_stb_o);

endmodule

// File: rtl/mrd_classifier.sv
module mrd_classifier
   import mrd_pkg::*;
#(
   parameter int unsigned CNT_W = 10,
   parameter int unsigned TOL   = 2
) (
   input  logic [1:0]       mode_i,
   input  logic [CNT_W-1:0] meas_i,
   output ratio_class_t     cls_o
);
   localparam int unsigned CW1 = CNT_W + 1;

   logic [RATIO_SLOTS-1:0] hit;
   logic [CW1-1:0]         ext;
   logic                   mode_ok;

   assign ext     = {1'b0, meas_i};
   assign mode_ok = (mode_i != MODE_UNSUPPORTED);

   generate
      for (genvar s = 0; s < RATIO_SLOTS; s++) begin : g_slot
         localparam int unsigned BR = base_ratio(s);
         logic [CW1-1:0] nominal;
         assign nominal = CW1'(BR) >> mode_i;
         if (TOL == 0) begin : g_exact
            assign hit[s] = mode_ok && (ext == nominal);
         end else begin : g_window
            logic [CW1-1:0] lo, hi;
            assign lo = nominal - CW1'(TOL);
            assign hi = nominal + CW1'(TOL);
            assign hit[s] = mode_ok && (ext >= lo) && (ext <= hi);
         end
      end
   endgenerate

   always_comb begin
      cls_o.bad  = 1'b1;
      cls_o.slot = 2'd0;
      for (int k = 0; k < RATIO_SLOTS; k++) begin
         if (hit[k]) begin
            cls_o.bad  = 1'b0;
            cls_o.slot = 2'(k);
         end
      end
   end

endmodule

// File: rtl/mrd_lock_tracker.sv
module mrd_lock_tracker
   import mrd_pkg::*;
#(
   parameter int unsigned LOCK_RUNS = 3
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         stb_i,
   input  ratio_class_t cls_i,
   output logic [1:0]   ratio_idx_o,
   output logic         valid_o,
   output logic         err_o,
   output logic         lock_o
);
   localparam int unsigned RW = $clog2(LOCK_RUNS + 1);

   ratio_class_t  cls_q;
   logic          seen_q;
   logic [RW-1:0] run_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cls_q  <= '0;
         seen_q <= 1'b0;
         run_q  <= '0;
      end else if (stb_i) begin
         seen_q <= 1'b1;
         cls_q  <= cls_i;
         if (seen_q && cls_i == cls_q) begin
            if (run_q < RW'(LOCK_RUNS)) run_q <= run_q + RW'(1);
         end else begin
            run_q <= RW'(1);
         end
      end
   end

   assign valid_o     = seen_q && !cls_q.bad;
   assign err_o       = seen_q && cls_q.bad;
   assign ratio_idx_o = valid_o ? cls_q.slot : 2'd0;
   assign lock_o      = valid_o && (run_q >= RW'(LOCK_RUNS));

   a_r8_lock_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_o |-> valid_o);

   a_r9_drop_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stb_i && seen_q && cls_i != cls_q) |=> !lock_o);

endmodule

// File: rtl/mclk_ratio_detector.sv
module mclk_ratio_detector
   import mrd_pkg::*;
#(
   parameter int unsigned CNT_W       = 10,
   parameter int unsigned TOL         = 2,
   parameter int unsigned LOCK_RUNS   = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       frame_clk_i,
   input  logic [1:0] mode_i,
   output logic [1:0] ratio_idx_o,
   output logic       valid_o,
   output logic       err_o,
   output logic       lock_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   generate
      if ((2 ** CNT_W) - 1 <= 768 + TOL) begin : g_bad_width
         $error("CNT_W too small for the largest ratio plus tolerance");
      end
      if (TOL >= 16) begin : g_bad_tol
         $error("TOL must keep the ratio windows disjoint");
      end
      if (LOCK_RUNS < 1) begin : g_bad_runs
         $error("LOCK_RUNS must be at least one");
      end
   endgenerate

   logic             rise;
   logic             meas_stb;
   logic [CNT_W-1:0] meas_cnt;
   logic             armed;
   ratio_class_t     cls;

   mrd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (frame_clk_i),
      .rise_o  (rise)
   );

   mrd_period_counter #(.CNT_W(CNT_W)) u_count (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rise_i     (rise),
      .meas_stb_o (meas_stb),
      .meas_cnt_o (meas_cnt),
      .armed_o    (armed)
   );

   mrd_classifier #(.CNT_W(CNT_W), .TOL(TOL)) u_class (
      .mode_i (mode_i),
      .meas_i (meas_cnt),
      .cls_o  (cls)
   );

   mrd_lock_tracker #(.LOCK_RUNS(LOCK_RUNS)) u_lock (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .stb_i       (meas_stb),
      .cls_i       (cls),
      .ratio_idx_o (ratio_idx_o),
      .valid_o     (valid_o),
      .err_o       (err_o),
      .lock_o      (lock_o)
   );

   a_r1_quiet_until_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !armed |-> (!valid_o && !err_o && !lock_o && ratio_idx_o == 2'd0));

   a_r7_valid_err_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(valid_o && err_o));

   a_r7_idx_zero_on_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |-> ratio_idx_o == 2'd0);

   a_r10_saturated_is_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (meas_stb && meas_cnt == CNT_MAX) |=> (err_o && !lock_o));

endmodule

// File: tb/mclk_ratio_detector_bench.sv
module mclk_ratio_detector_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_clk = 1'b0;
   logic [1:0] mode = 2'd0;
   logic [1:0] ratio_idx;
   logic       valid, err, lock;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   mclk_ratio_detector u_mclk_ratio_detector (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .frame_clk_i (frame_clk),
      .mode_i      (mode),
      .ratio_idx_o (ratio_idx),
      .valid_o     (valid),
      .err_o       (err),
      .lock_o      (lock)
   );

   // reference model state
   bit      m_armed = 0;
   bit      m_seen = 0;
   int      m_prev_len = 0;
   bit [2:0] m_cls = 0;   // {bad, slot}
   int      m_run = 0;

   function automatic int nominal(int slot, int md);
      int lowr [4] = '{256, 384, 512, 768};
      return lowr[slot] >> md;
   endfunction

   function automatic bit [2:0] classify(int len, int md);
      bit [2:0] c = 3'b100;
      if (md == 3) return c;
      for (int s = 0; s < 4; s++) begin
         int d = len - nominal(s, md);
         if (d >= -2 && d <= 2) c = {1'b0, 2'(s)};
      end
      return c;
   endfunction

   function automatic void apply_meas(int len);
      bit [2:0] c = classify(len, int'(mode));
      if (m_seen && c == m_cls) begin
         if (m_run < 3) m_run++;
      end else m_run = 1;
      m_cls = c;
      m_seen = 1;
   endfunction

   task automatic check(string tag, bit [1:0] a_idx, bit a_v, bit a_e, bit a_l);
      bit       ev = m_seen && !m_cls[2];
      bit       ee = m_seen && m_cls[2];
      bit [1:0] ei = ev ? m_cls[1:0] : 2'd0;
      bit       el = ev && m_run >= 3;
      checks++;
      if ({a_idx, a_v, a_e} !== {ei, ev, ee}) begin
         failures++;
         $display("FAIL %s idx/valid/err actual=%0d/%0b/%0b expected=%0d/%0b/%0b",
                  tag, a_idx, a_v, a_e, ei, ev, ee);
      end
      checks++;
      if (a_l !== el) begin
         failures++;
         $display("FAIL %s lock actual=%0b expected=%0b", tag, a_l, el);
      end
   endtask

   // One frame period of p cycles; starts and ends at a falling clock edge
   task automatic period(int p, string tag);
      frame_clk = 1'b1;
      if (m_armed) apply_meas(m_prev_len);
      m_armed = 1;
      m_prev_len = p;
      repeat (p / 2) @(negedge clk);
      check(tag, ratio_idx, valid, err, lock);
      frame_clk = 1'b0;
      repeat (p - p / 2) @(negedge clk);
   endtask

   task automatic stall(int cycles);
      frame_clk = 1'b0;
      repeat (cycles) @(negedge clk);
      apply_meas(1023);
      m_prev_len = 1023;
      check("R10", ratio_idx, valid, err, lock);
   endtask

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      checks++;   // R1: reset state
      if ({ratio_idx, valid, err, lock} !== 5'b0) begin
         failures++;
         $display("FAIL R1 reset outputs actual=%b expected=00000", {ratio_idx, valid, err, lock});
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R1: first period only arms; R2/R3: exact 512 in low mode, locks (R8)
      mode = 2'd0;
      period(512, "R1");
      period(512, "R2");
      period(512, "R3");
      period(512, "R8");
      period(512, "R8");
      // R6: tolerance edges keep the same slot and the lock
      period(514, "R6");
      period(510, "R6");
      period(512, "R6");
      // R9: change slot drops lock, R6: 3 cycles off is error
      period(768, "R9");
      period(771, "R9");
      period(768, "R6");
      // R4 and R5 directed
      mode = 2'd1;
      period(128, "R4");
      period(192, "R4");
      period(192, "R4");
      mode = 2'd2;
      period(96, "R5");
      period(64, "R5");
      period(64, "R5");
      period(64, "R5");
      period(66, "R8");
      // R7: unsupported mode
      mode = 2'd3;
      period(128, "R9");
      period(128, "R7");
      // R10: lock, then stop the frame clock, then recover
      mode = 2'd0;
      period(384, "R7");
      period(384, "R8");
      period(384, "R8");
      period(384, "R8");
      stall(1100);
      period(384, "R10");
      period(384, "R10");

      // constrained random mix
      for (int it = 0; it < 60; it++) begin
         int sel = $urandom_range(0, 9);
         int md = $urandom_range(0, 2);
         int n = $urandom_range(1, 4);
         int len;
         int slot = $urandom_range(0, 3);
         if (sel == 9) md = 3;
         len = nominal(slot, (md == 3) ? 1 : md);
         if (sel <= 5) len += $urandom_range(0, 4) - 2;
         else if (sel <= 7) len += ($urandom_range(0, 1) == 1) ? 3 : -3;
         else if (sel == 8) len = $urandom_range(40, 900);
         mode = 2'(md);
         for (int k = 0; k < n; k++) period(len, (md == 3) ? "R7" : "R6");
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule